// File: doc/BRIEF.md
# Character overlay raster generator

This block produces the timing that places a grid of character cells on top of a video picture. The grid is 24 cells across and 12 rows down, and each cell is 12 dots wide and 18 lines tall. The block takes the incoming horizontal and vertical sync pulses and a dot clock. From these it works out, on every clock, which cell is being drawn, which dot column and which font line within that cell apply, and whether the current position belongs to a visible cell.

The display memory is read from outside the block using the address output, which is row × 24 + column. The blink attribute of the addressed character comes back on `cell_blink_i`. The font row for the current code and line comes back on `font_row_i` in the same cycle. The block then chooses the lit dot from that row, applies reverse video and the display enable, and hides blinking characters in the off half of the blink period. It also raises a background qualifier that covers the whole cell when blanking is enabled.

The start of the grid can be moved in 64 horizontal and 64 vertical steps. Each dot can be stretched to 1, 2 or 3 clocks, and each font line to 1, 2 or 3 scan lines. A cell that would reach past the right edge of the screen or the bottom edge of the screen is dropped as a whole.

Top module: `osd_raster`

## Requirements
- R1: After reset, all counters and the field count are zero and every output is 0. `active_o` stays 0 until the first rising edge of `vsync_i` after reset.
- R2: The horizontal start is `hpos_i`×4 clocks. Counting starts with position 0 on the first clock edge after the edge that sees `hsync_i` rise. Dot width code `hsize_i` selects the clocks per dot: 0 gives 1, 1 gives 2, and 2 or 3 gives 3. `dot_col_o` counts 0 to 11 within a cell.
- R3: A rising edge of `vsync_i` resets the row and line state. The `hsync_i` rise with index `vpos_i`×2, counted from 0 after that vsync, starts grid line 0. Line height code `vsize_i` selects the scan lines per font line with the same encoding as R2. `line_o` counts 0 to 17.
- R4: `addr_o` equals row×24 + column and is held for every clock of a cell.
- R5: `pix_o` takes font bit 11 − `dot_col_o`, so bit 11 is the leftmost dot.
- R6: A column whose last clock position, hstart + (col+1)×12×dot width, exceeds 720 is not active. The whole cell is dropped.
- R7: A row whose end line, vstart + (row+1)×18×line height, exceeds 250 is not active.
- R8: After column 23 ends, the line is inactive until the next `hsync_i` rise. The column and dot outputs hold at 23 and 11.
- R9: When `disp_en_i` is 0, `pix_o` and `bg_o` are 0.
- R10: `reverse_i` = 1 inverts each font bit before it reaches `pix_o`.
- R11: When `blank_en_i` = 1, `bg_o` is 1 on every clock of an active cell, whatever the font bits are.
- R12: The blink period is P fields, where P is 50 when `pal_i` = 1 and 60 otherwise, and P is halved when `blink_fast_i` = 1. The field count is the number of `vsync_i` rises modulo P. `blink_o` is 1 when the count is at least P/2 (integer division).
- R13: `blink_o` and pix hiding apply only when `cell_blink_i` = 1. A hidden character gives `pix_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync, rising edge used |
| vsync_i | input | 1 | Vertical sync, rising edge used |
| hpos_i | input | 6 | Horizontal start step (×4 clocks) |
| vpos_i | input | 6 | Vertical start step (×2 lines) |
| hsize_i | input | 2 | Clocks per dot code |
| vsize_i | input | 2 | Scan lines per font line code |
| disp_en_i | input | 1 | Character output enable |
| reverse_i | input | 1 | Reverse video |
| blank_en_i | input | 1 | Whole-cell background enable |
| pal_i | input | 1 | 50-field blink base when 1, 60 when 0 |
| blink_fast_i | input | 1 | Halves the blink period |
| cell_blink_i | input | 1 | Blink attribute of the addressed character |
| font_row_i | input | 12 | Font dots of the current code and line |
| addr_o | output | 9 | Display memory address |
| dot_col_o | output | 4 | Dot column within cell |
| line_o | output | 5 | Font line within cell |
| active_o | output | 1 | Current position is inside a visible cell |
| pix_o | output | 1 | Lit character dot |
| bg_o | output | 1 | Cell background qualifier |
| blink_o | output | 1 | Character hidden by blinking |

## Verification
The hardest conditions to reach are the edge clipping cases. A cell is dropped only when enlargement and the start offset push its far edge past the screen limit. The stimulus therefore places the sampling point exactly on the last kept cell and on the first dropped one, horizontally at 3-clock dots and vertically at double-height lines. It does this after long runs of short sync-driven lines that walk the vertical state down the screen. Reaching the blink phases needs dozens of fields, so the bench resets the block and then issues counted vsync-only pulses. This puts the field count on either side of the half-period threshold for each of the four period settings.

// File: rtl/osd_pkg.sv
package osd_pkg;
  // size code -> repeat count (1..3)
  function automatic logic [1:0] mag_of(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/osd_hscan.sv
module osd_hscan #(
  parameter int COLS    = 24,
  parameter int CELL_W  = 12,
  parameter int POS_W   = 6,
  parameter int H_STEP  = 4,
  parameter int H_LIMIT = 720,
  parameter int HC_W    = 12,
  parameter int COL_W   = 5,
  parameter int DOT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic [POS_W-1:0] hpos_i,
  input  logic [1:0]       mag_i,
  output logic [COL_W-1:0] col_o,
  output logic [DOT_W-1:0] dot_o,
  output logic             act_o
);
  localparam int EW = HC_W + 4;

  logic [HC_W-1:0] hcnt, hstart;
  logic            hact, hdone;
  logic [1:0]      st;
  logic [EW-1:0]   cell_end;

  assign hstart   = HC_W'(hpos_i) * HC_W'(H_STEP);
  assign cell_end = EW'(hstart) + (EW'(col_o) + EW'(1)) * EW'(CELL_W) * EW'(mag_i);
  assign act_o    = hact && (cell_end <= EW'(H_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt  <= '0;
      hact  <= 1'b0;
      hdone <= 1'b0;
      col_o <= '0;
      dot_o <= '0;
      st    <= '0;
    end else if (hs_rise_i) begin
      hcnt  <= '0;
      hact  <= 1'b0;
      hdone <= 1'b0;
      col_o <= '0;
      dot_o <= '0;
      st    <= '0;
    end else begin
      if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (!hact && !hdone) begin
        if (hcnt == hstart) begin
          hact  <= 1'b1;
          col_o <= '0;
          dot_o <= '0;
          st    <= '0;
        end
      end else if (hact) begin
        if (st >= mag_i - 2'd1) begin
          st <= '0;
          if (dot_o == DOT_W'(CELL_W-1)) begin
            if (col_o == COL_W'(COLS-1)) begin
              hact  <= 1'b0;   // grid done, hold col/dot
              hdone <= 1'b1;
            end else begin
              col_o <= col_o + 1'b1;
              dot_o <= '0;
            end
          end else begin
            dot_o <= dot_o + 1'b1;
          end
        end else begin
          st <= st + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_vscan.sv
module osd_vscan #(
  parameter int ROWS    = 12,
  parameter int CELL_H  = 18,
  parameter int POS_W   = 6,
  parameter int V_STEP  = 2,
  parameter int V_LIMIT = 250,
  parameter int VC_W    = 10,
  parameter int ROW_W   = 4,
  parameter int LINE_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vs_rise_i,
  input  logic              hs_rise_i,
  input  logic [POS_W-1:0]  vpos_i,
  input  logic [1:0]        mag_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [LINE_W-1:0] line_o,
  output logic              act_o
);
  localparam int EW = VC_W + 4;

  logic [VC_W-1:0] vcnt, vstart;
  logic            vact, vdone;
  logic [1:0]      st;
  logic [EW-1:0]   row_end;

  assign vstart  = VC_W'(vpos_i) * VC_W'(V_STEP);
  assign row_end = EW'(vstart) + (EW'(row_o) + EW'(1)) * EW'(CELL_H) * EW'(mag_i);
  assign act_o   = vact && (row_end <= EW'(V_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt   <= '0;
      vact   <= 1'b0;
      vdone  <= 1'b0;
      row_o  <= '0;
      line_o <= '0;
      st     <= '0;
    end else if (vs_rise_i) begin
      vcnt   <= '0;
      vact   <= 1'b0;
      vdone  <= 1'b0;
      row_o  <= '0;
      line_o <= '0;
      st     <= '0;
    end else if (hs_rise_i) begin
      if (vcnt != '1) vcnt <= vcnt + 1'b1;
      if (!vact && !vdone) begin
        if (vcnt == vstart) begin
          vact   <= 1'b1;
          row_o  <= '0;
          line_o <= '0;
          st     <= '0;
        end
      end else if (vact) begin
        if (st >= mag_i - 2'd1) begin
          st <= '0;
          if (line_o == LINE_W'(CELL_H-1)) begin
            if (row_o == ROW_W'(ROWS-1)) begin
              vact  <= 1'b0;
              vdone <= 1'b1;
            end else begin
              row_o  <= row_o + 1'b1;
              line_o <= '0;
            end
          end else begin
            line_o <= line_o + 1'b1;
          end
        end else begin
          st <= st + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_blink.sv
module osd_blink #(
  parameter int FIELDS_PAL  = 50,
  parameter int FIELDS_NTSC = 60,
  parameter int FC_W        = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_rise_i,
  input  logic pal_i,
  input  logic fast_i,
  output logic hide_o
);
  logic [FC_W-1:0] fcnt, full, period, nxt;

  assign full   = pal_i ? FC_W'(FIELDS_PAL) : FC_W'(FIELDS_NTSC);
  assign period = fast_i ? (full >> 1) : full;
  assign nxt    = fcnt + 1'b1;
  assign hide_o = fcnt >= (period >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fcnt <= '0;
    else if (vs_rise_i) fcnt <= (nxt >= period) ? '0 : nxt;
  end
endmodule

// File: rtl/osd_raster.sv
module osd_raster #(
  parameter int COLS        = 24,
  parameter int ROWS        = 12,
  parameter int CELL_W      = 12,
  parameter int CELL_H      = 18,
  parameter int POS_W       = 6,
  parameter int H_STEP      = 4,
  parameter int V_STEP      = 2,
  parameter int H_LIMIT     = 720,
  parameter int V_LIMIT     = 250,
  parameter int FIELDS_PAL  = 50,
  parameter int FIELDS_NTSC = 60,
  localparam int ADDR_W = $clog2(COLS*ROWS),
  localparam int DOT_W  = $clog2(CELL_W),
  localparam int LINE_W = $clog2(CELL_H)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [POS_W-1:0]  hpos_i,
  input  logic [POS_W-1:0]  vpos_i,
  input  logic [1:0]        hsize_i,
  input  logic [1:0]        vsize_i,
  input  logic              disp_en_i,
  input  logic              reverse_i,
  input  logic              blank_en_i,
  input  logic              pal_i,
  input  logic              blink_fast_i,
  input  logic              cell_blink_i,
  input  logic [CELL_W-1:0] font_row_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DOT_W-1:0]  dot_col_o,
  output logic [LINE_W-1:0] line_o,
  output logic              active_o,
  output logic              pix_o,
  output logic              bg_o,
  output logic              blink_o
);
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int HC_W  = $clog2((2**POS_W)*H_STEP + COLS*CELL_W*3 + 2);
  localparam int VC_W  = $clog2((2**POS_W)*V_STEP + ROWS*CELL_H*3 + 2);
  localparam int FMAX  = (FIELDS_PAL > FIELDS_NTSC) ? FIELDS_PAL : FIELDS_NTSC;
  localparam int FC_W  = $clog2(FMAX + 1);

  logic hs_q, vs_q, frame_seen;
  logic hs_rise, vs_rise;
  logic h_act, v_act, hide;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic [DOT_W-1:0]  bit_idx;
  logic [ADDR_W-1:0] row_x, col_x;
  logic              lit;

  assign hs_rise = hsync_i & ~hs_q;
  assign vs_rise = vsync_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q       <= 1'b0;
      vs_q       <= 1'b0;
      frame_seen <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      if (vs_rise) frame_seen <= 1'b1;
    end
  end

  osd_hscan #(
    .COLS(COLS), .CELL_W(CELL_W), .POS_W(POS_W), .H_STEP(H_STEP),
    .H_LIMIT(H_LIMIT), .HC_W(HC_W), .COL_W(COL_W), .DOT_W(DOT_W)
  ) u_hscan (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_rise_i(hs_rise), .hpos_i(hpos_i),
    .mag_i(osd_pkg::mag_of(hsize_i)), .col_o(col), .dot_o(dot_col_o), .act_o(h_act)
  );

  osd_vscan #(
    .ROWS(ROWS), .CELL_H(CELL_H), .POS_W(POS_W), .V_STEP(V_STEP),
    .V_LIMIT(V_LIMIT), .VC_W(VC_W), .ROW_W(ROW_W), .LINE_W(LINE_W)
  ) u_vscan (
    .clk_i(clk_i), .rst_ni(rst_ni), .vs_rise_i(vs_rise), .hs_rise_i(hs_rise),
    .vpos_i(vpos_i), .mag_i(osd_pkg::mag_of(vsize_i)), .row_o(row),
    .line_o(line_o), .act_o(v_act)
  );

  osd_blink #(
    .FIELDS_PAL(FIELDS_PAL), .FIELDS_NTSC(FIELDS_NTSC), .FC_W(FC_W)
  ) u_blink (
    .clk_i(clk_i), .rst_ni(rst_ni), .vs_rise_i(vs_rise), .pal_i(pal_i),
    .fast_i(blink_fast_i), .hide_o(hide)
  );

  assign row_x    = ADDR_W'(row);
  assign col_x    = ADDR_W'(col);
  assign addr_o   = row_x * ADDR_W'(COLS) + col_x;
  assign active_o = frame_seen && h_act && v_act;

  // leftmost dot is the MSB of the font row
  assign bit_idx  = DOT_W'(CELL_W-1) - dot_col_o;
  assign lit      = font_row_i[bit_idx] ^ reverse_i;
  assign blink_o  = cell_blink_i && hide;
  assign pix_o    = active_o && disp_en_i && !blink_o && lit;
  assign bg_o     = active_o && disp_en_i && blank_en_i;
endmodule

// File: rtl/osd_raster_chk.sv
module osd_raster_chk #(
  parameter int COLS   = 24,
  parameter int ROWS   = 12,
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  parameter int ADDR_W = 9,
  parameter int DOT_W  = 4,
  parameter int LINE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic              disp_en_i,
  input logic              blank_en_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DOT_W-1:0]  dot_col_o,
  input logic [LINE_W-1:0] line_o,
  input logic              active_o,
  input logic              pix_o,
  input logic              bg_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen <= 1'b0;
    else if (vsync_i) seen <= 1'b1;
  end

  p_no_active_pre_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen |-> !active_o);

  p_dot_in_cell_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_col_o < DOT_W'(CELL_W));

  p_line_in_cell_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o < LINE_W'(CELL_H));

  p_line_reset_vsync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_i) |=> (line_o == '0));

  p_addr_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o < ADDR_W'(COLS*ROWS));

  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !hsync_i && !vsync_i) |=>
      (!active_o || dot_col_o == '0 || $stable(addr_o)));

  p_pix_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_o |-> (disp_en_i && active_o));

  p_bg_needs_blank_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bg_o |-> (blank_en_i && disp_en_i && active_o));
endmodule

bind osd_raster osd_raster_chk #(
  .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
  .ADDR_W(ADDR_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vsync_i(vsync_i),
  .disp_en_i(disp_en_i), .blank_en_i(blank_en_i), .addr_o(addr_o),
  .dot_col_o(dot_col_o), .line_o(line_o), .active_o(active_o),
  .pix_o(pix_o), .bg_o(bg_o)
);

// File: tb/tb_osd_raster.sv
module tb_osd_raster;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic [5:0] hpos = '0, vpos = '0;
  logic [1:0] hsize = '0, vsize = '0;
  logic disp_en = 1'b1, reverse = 1'b0, blank_en = 1'b0;
  logic pal = 1'b1, fast = 1'b0, cell_blink = 1'b0;
  logic [11:0] font = '0;
  logic [8:0] addr;
  logic [3:0] dot;
  logic [4:0] line;
  logic active, pix, bg, blink;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  osd_raster dut (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync), .vsync_i(vsync),
    .hpos_i(hpos), .vpos_i(vpos), .hsize_i(hsize), .vsize_i(vsize),
    .disp_en_i(disp_en), .reverse_i(reverse), .blank_en_i(blank_en),
    .pal_i(pal), .blink_fast_i(fast), .cell_blink_i(cell_blink),
    .font_row_i(font), .addr_o(addr), .dot_col_o(dot), .line_o(line),
    .active_o(active), .pix_o(pix), .bg_o(bg), .blink_o(blink)
  );

  typedef struct packed {
    int hp; int vp; int hc; int vc; int ln; int px;
    int act; int adr; int dt; int fl;
  } vec_t;

  // hpos, vpos, hsize, vsize, line index, position -> active, addr, dot, font line
  localparam vec_t VECS [13] = '{
    '{0,  0, 0, 0,   0,   0, 1,   0,  0,  0},
    '{2,  1, 1, 0,  25,  95, 1,  27,  7,  5},
    '{0,  0, 2, 1,  82, 719, 1,  67, 11,  5},
    '{0,  0, 2, 1,  82, 720, 0,  68,  0,  5},
    '{0,  0, 0, 1, 216,   0, 0, 144,  0,  0},
    '{0,  0, 0, 1, 215,   0, 1, 120,  0, 17},
    '{5,  0, 0, 0,   0,  19, 0,   0,  0,  0},
    '{5,  0, 0, 0,   0,  20, 1,   0,  0,  0},
    '{0,  3, 0, 0,   5,   0, 0,   0,  0,  0},
    '{0,  0, 0, 0,   0, 288, 0,  23, 11,  0},
    '{63, 0, 0, 0,   0, 252, 1,   0,  0,  0},
    '{0, 63, 0, 0, 126,   0, 1,   0,  0,  0},
    '{0, 63, 0, 0, 234,   0, 0, 144,  0,  0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic pulse_vs();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic pulse_hs();
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
  endtask

  // new field, skip ln lines, then stop at position px of line ln
  task automatic goto(input int ln, input int px);
    pulse_vs();
    for (int k = 0; k < ln; k++) begin
      pulse_hs();
      repeat (3) @(negedge clk);
    end
    pulse_hs();
    repeat (px + 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic blink_case(input logic p, input logic f, input int nvs, input int hidden);
    do_reset();
    pal = p; fast = f;
    for (int k = 0; k < nvs - 1; k++) pulse_vs();
    goto(0, 0);
    chk("R12 blink phase", int'(blink), hidden);
    chk("R12 R13 hidden pixel", int'(pix), 1 - hidden);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 reset active", int'(active), 0);
    chk("R1 reset addr", int'(addr), 0);
    chk("R1 reset dot", int'(dot), 0);
    chk("R1 reset line", int'(line), 0);
    chk("R1 reset pix", int'(pix), 0);
    chk("R1 reset bg", int'(bg), 0);
    chk("R1 reset blink", int'(blink), 0);
    rst_ni = 1'b1;

    // R1: no active region before first vsync
    pulse_hs();
    repeat (2) @(negedge clk);
    chk("R1 pre-vsync active", int'(active), 0);
    goto(0, 0);
    chk("R1 post-vsync active", int'(active), 1);

    // table walk: R2 R3 R4 R6 R7 R8
    for (int i = 0; i < 13; i++) begin
      hpos = 6'(VECS[i].hp); vpos = 6'(VECS[i].vp);
      hsize = 2'(VECS[i].hc); vsize = 2'(VECS[i].vc);
      goto(VECS[i].ln, VECS[i].px);
      chk("R2 R3 R6 R7 R8 vec active", int'(active), VECS[i].act);
      chk("R4 vec addr", int'(addr), VECS[i].adr);
      chk("R2 vec dot", int'(dot), VECS[i].dt);
      chk("R3 vec line", int'(line), VECS[i].fl);
    end

    // R5: MSB is leftmost dot
    hpos = '0; vpos = '0; hsize = '0; vsize = '0;
    font = 12'h801;
    goto(0, 0);
    chk("R5 dot0 msb", int'(pix), 1);
    @(negedge clk);
    chk("R5 dot1", int'(pix), 0);
    repeat (10) @(negedge clk);
    chk("R5 dot11 lsb", int'(pix), 1);
    // R2: stretched dot keeps font bit
    hsize = 2'd1;
    goto(0, 1);
    chk("R2 stretch dot0 second clock", int'(pix), 1);
    @(negedge clk);
    chk("R2 stretch dot1", int'(pix), 0);
    hsize = '0;

    // R10: reverse video
    reverse = 1'b1;
    goto(0, 0);
    chk("R10 reverse lit", int'(pix), 0);
    @(negedge clk);
    chk("R10 reverse unlit", int'(pix), 1);
    reverse = 1'b0;

    // R11: blanking background
    font = '0; blank_en = 1'b1;
    goto(0, 5);
    chk("R11 bg in cell", int'(bg), 1);
    chk("R11 no dots", int'(pix), 0);
    goto(0, 288);
    chk("R11 bg outside grid", int'(bg), 0);

    // R9: display disabled
    font = 12'hfff; disp_en = 1'b0;
    goto(0, 3);
    chk("R9 pix off", int'(pix), 0);
    chk("R9 bg off", int'(bg), 0);
    disp_en = 1'b1; blank_en = 1'b0;

    // R12/R13 blink
    cell_blink = 1'b1;
    blink_case(1'b1, 1'b0, 25, 1);
    blink_case(1'b1, 1'b0, 24, 0);
    blink_case(1'b1, 1'b0, 50, 0);
    blink_case(1'b1, 1'b1, 12, 1);
    blink_case(1'b1, 1'b1, 11, 0);
    blink_case(1'b0, 1'b0, 30, 1);
    blink_case(1'b0, 1'b0, 29, 0);
    blink_case(1'b0, 1'b1, 15, 1);
    blink_case(1'b0, 1'b1, 14, 0);
    // R13: non-blinking character unaffected in hidden phase
    cell_blink = 1'b0;
    blink_case(1'b1, 1'b0, 25, 0);

    summary();
  end
endmodule